// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks a singly linked chain of 32-bit capability headers stored in a 4 KB configuration space. The configuration space sits outside the block behind a synchronous single-port memory: one word address per cycle, with read data returned on the following cycle. Each header holds a 16-bit identifier in bits [15:0], a 4-bit version in bits [19:16] and a 12-bit byte offset of the next header in bits [31:20]. A next offset of zero ends the chain. The chain always starts at byte offset 256. An all-zero word there means the chain is empty.

A lookup command takes an identifier. It reports whether a header with that identifier exists, the header's byte offset, and the offset of the header that precedes it. An append command places a new header at a given offset. At offset 256 the new header keeps the next pointer already stored there. At any other offset the block first finds the tail, rewrites only the tail's next field, and then writes the new header with a next pointer of zero. Each command ends with a one-cycle done pulse. The results stay on the outputs until the next command ends.

Top module: `ecap_walker`

## Requirements
- R1: A lookup for a nonzero identifier reads headers starting at offset 256 and follows bits [31:20]. On the first header whose bits [15:0] equal the identifier it reports found=1, err=0, pos=that offset, and prev=the offset of the header read before it (0 when the match is at 256).
- R2: If the word at offset 256 is all zero, a lookup reports found=0, err=0, pos=0 and prev=0 after reading that single word.
- R3: A lookup that reaches a header with next pointer 0 and no match reports found=0, err=0, pos=0, and prev=the offset of that last header.
- R4: Identifier 0 never matches, even a stored header whose identifier field is 0. A lookup for 0 therefore ends at the tail and reports its offset as prev.
- R5: A nonzero next pointer below 256 or above 4088 stops the walk with err=1, found=0, pos=0 and prev=0.
- R6: A walk that has read MAX_STEPS headers (default 1024) and still finds a nonzero next pointer stops with err=1, so a circular chain ends the command.
- R7: An append at offset 256 reads that word and then writes {old bits [31:20], version, identifier} there. It reports err=0, pos=256, prev=0.
- R8: An append elsewhere walks to the tail and writes the tail back with bits [31:20] replaced by the new offset and bits [19:0] unchanged. It then writes {12'h000, version, identifier} at the new offset, and reports err=0, pos=new offset, prev=tail offset.
- R9: An append is rejected with err=1 and no memory access if any of these holds: the offset is not a multiple of 4, the offset is below 256, the size is below 8, or offset+size is 4096 or more. Its done pulse comes in the cycle after the command.
- R10: An append at an offset other than 256 on an empty chain ends with err=1 and writes nothing.
- R11: done is a single-cycle pulse with busy low. For a walk reading n headers, a lookup's done comes 2n+1 cycles after the command cycle, an append at 256 takes 4 cycles, and an append elsewhere takes 2n+3 cycles.
- R12: Commands that arrive while busy are ignored. When lookup and append are requested together, the lookup is taken and the append is dropped.
- R13: Memory read and write strobes are never active in the same cycle, and neither is active while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| find_i | input | 1 | Lookup command pulse |
| add_i | input | 1 | Append command pulse |
| cap_id_i | input | 16 | Identifier to look up or append |
| cap_ver_i | input | 4 | Version for an appended header |
| offset_i | input | 12 | Byte offset for an appended header |
| size_i | input | 13 | Byte size of the appended region |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Result pulse |
| found_o | output | 1 | Identifier was found |
| err_o | output | 1 | Command aborted or rejected |
| pos_o | output | 12 | Offset of match, or of the appended header |
| prev_o | output | 12 | Offset of preceding or tail header |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 10 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after mem_re_o |

## Verification
Lookups are tried on an empty chain, and on a three-entry chain built only through the block's own appends, for the first, middle and last entries and for an absent identifier. Together these separate match reporting from tail reporting and confirm the 2n+1 latency for each chain length. Broken chains cover the range limits and their boundaries: a pointer to 4088 must be followed, while pointers to 252 and 4092 must abort. They also include a stored zero identifier that must not match, and a self-loop that only the step bound can end. Append tests cover the head rewrite, the tail patch and each rejection rule. Commands issued while busy, and simultaneous commands, must leave both the result and the memory as if only the first lookup had been issued.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 16;
  localparam int unsigned VER_W  = 4;

  typedef struct packed {
    logic [OFF_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } cap_hdr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CHK, S_WR_TAIL, S_WR_NEW
  } walk_state_e;

  typedef enum logic [1:0] {
    OP_FIND, OP_ADD_HEAD, OP_ADD_TAIL
  } walk_op_e;
endpackage

// File: rtl/ecap_off_chk.sv
module ecap_off_chk #(
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned LIST_BASE = 256
) (
  input  logic [OFF_W-1:0] off_i,
  output logic             ok_o
);
  localparam int unsigned SPACE   = 1 << OFF_W;
  localparam int unsigned LAST_OK = SPACE - 8;

  assign ok_o = (off_i >= OFF_W'(LIST_BASE)) && (off_i <= OFF_W'(LAST_OK));
endmodule

// File: rtl/ecap_add_chk.sv
module ecap_add_chk #(
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned LIST_BASE = 256
) (
  input  logic [OFF_W-1:0] offset_i,
  input  logic [OFF_W:0]   size_i,
  output logic             ok_o
);
  localparam int unsigned SPACE = 1 << OFF_W;
  localparam int unsigned SUM_W = OFF_W + 2;

  logic [SUM_W-1:0] end_w;
  assign end_w = SUM_W'(offset_i) + SUM_W'(size_i);

  assign ok_o = (offset_i >= OFF_W'(LIST_BASE)) && (offset_i[1:0] == 2'b00) &&
                (size_i >= (OFF_W+1)'(8)) && (end_w < SUM_W'(SPACE));
endmodule

// File: rtl/ecap_step_ctr.sv
module ecap_step_ctr #(
  parameter int unsigned MAX_STEPS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // true while the header now being checked is the last one allowed
  assign last_o = (cnt_q == CW'(MAX_STEPS - 1));
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int unsigned LIST_BASE = 256,
  parameter int unsigned MAX_STEPS = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                find_i,
  input  logic                add_i,
  input  logic [ID_W-1:0]     cap_id_i,
  input  logic [VER_W-1:0]    cap_ver_i,
  input  logic [OFF_W-1:0]    offset_i,
  input  logic [OFF_W:0]      size_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                found_o,
  output logic                err_o,
  output logic [OFF_W-1:0]    pos_o,
  output logic [OFF_W-1:0]    prev_o,
  output logic                mem_re_o,
  output logic                mem_we_o,
  output logic [OFF_W-3:0]    mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic [WORD_W-1:0]   mem_rdata_i
);
  localparam logic [OFF_W-1:0] BASE = OFF_W'(LIST_BASE);

  walk_state_e      state_q;
  walk_op_e         op_q;
  logic [ID_W-1:0]  key_q, new_id_q;
  logic [VER_W-1:0] new_ver_q;
  logic [OFF_W-1:0] new_off_q, cur_q, prv_q, link_q;
  cap_hdr_t         tail_q, hdr;
  logic             done_q, found_q, err_q;
  logic [OFF_W-1:0] pos_q, prev_q;
  logic             nxt_ok, add_ok, step_last;
  logic             start_any, advance;

  assign hdr = cap_hdr_t'(mem_rdata_i);

  ecap_off_chk #(.OFF_W(OFF_W), .LIST_BASE(LIST_BASE)) u_off_chk (
    .off_i(hdr.nxt), .ok_o(nxt_ok)
  );

  ecap_add_chk #(.OFF_W(OFF_W), .LIST_BASE(LIST_BASE)) u_add_chk (
    .offset_i(offset_i), .size_i(size_i), .ok_o(add_ok)
  );

  assign start_any = (state_q == S_IDLE) && (find_i || (add_i && add_ok));
  assign advance   = (state_q == S_CHK) && (op_q != OP_ADD_HEAD) &&
                     !(cur_q == BASE && mem_rdata_i == '0) &&
                     !(op_q == OP_FIND && key_q != '0 && hdr.id == key_q) &&
                     (hdr.nxt != '0) && nxt_ok && !step_last;

  ecap_step_ctr #(.MAX_STEPS(MAX_STEPS)) u_steps (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_any), .inc_i(advance),
    .last_o(step_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= OP_FIND;
      key_q     <= '0;
      new_id_q  <= '0;
      new_ver_q <= '0;
      new_off_q <= '0;
      cur_q     <= '0;
      prv_q     <= '0;
      link_q    <= '0;
      tail_q    <= '0;
      done_q    <= 1'b0;
      found_q   <= 1'b0;
      err_q     <= 1'b0;
      pos_q     <= '0;
      prev_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (find_i) begin
            op_q    <= OP_FIND;
            key_q   <= cap_id_i;
            cur_q   <= BASE;
            prv_q   <= '0;
            state_q <= S_RD;
          end else if (add_i) begin
            if (!add_ok) begin
              done_q <= 1'b1; found_q <= 1'b0; err_q <= 1'b1;
              pos_q  <= '0;   prev_q  <= '0;
            end else begin
              op_q      <= (offset_i == BASE) ? OP_ADD_HEAD : OP_ADD_TAIL;
              key_q     <= '0;
              new_id_q  <= cap_id_i;
              new_ver_q <= cap_ver_i;
              new_off_q <= offset_i;
              cur_q     <= BASE;
              prv_q     <= '0;
              state_q   <= S_RD;
            end
          end
        end
        S_RD: state_q <= S_CHK;
        S_CHK: begin
          if (op_q == OP_ADD_HEAD) begin
            link_q  <= hdr.nxt;
            state_q <= S_WR_NEW;
          end else if (cur_q == BASE && mem_rdata_i == '0) begin
            done_q <= 1'b1; found_q <= 1'b0; err_q <= (op_q != OP_FIND);
            pos_q  <= '0;   prev_q  <= '0;   state_q <= S_IDLE;
          end else if (op_q == OP_FIND && key_q != '0 && hdr.id == key_q) begin
            done_q <= 1'b1; found_q <= 1'b1; err_q <= 1'b0;
            pos_q  <= cur_q; prev_q <= prv_q; state_q <= S_IDLE;
          end else if (hdr.nxt == '0) begin
            if (op_q == OP_FIND) begin
              done_q <= 1'b1; found_q <= 1'b0; err_q <= 1'b0;
              pos_q  <= '0;   prev_q  <= cur_q; state_q <= S_IDLE;
            end else begin
              tail_q  <= hdr;
              link_q  <= '0;
              state_q <= S_WR_TAIL;
            end
          end else if (!nxt_ok || step_last) begin
            done_q <= 1'b1; found_q <= 1'b0; err_q <= 1'b1;
            pos_q  <= '0;   prev_q  <= '0;   state_q <= S_IDLE;
          end else begin
            prv_q   <= cur_q;
            cur_q   <= hdr.nxt;
            state_q <= S_RD;
          end
        end
        S_WR_TAIL: state_q <= S_WR_NEW;
        S_WR_NEW: begin
          done_q <= 1'b1; found_q <= 1'b0; err_q <= 1'b0;
          pos_q  <= new_off_q;
          prev_q <= (op_q == OP_ADD_HEAD) ? '0 : cur_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_re_o    = (state_q == S_RD);
    mem_we_o    = (state_q == S_WR_TAIL) || (state_q == S_WR_NEW);
    mem_addr_o  = (state_q == S_WR_NEW) ? new_off_q[OFF_W-1:2] : cur_q[OFF_W-1:2];
    mem_wdata_o = (state_q == S_WR_TAIL) ? {new_off_q, tail_q.ver, tail_q.id}
                                         : {link_q, new_ver_q, new_id_q};
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign found_o = found_q;
  assign err_o   = err_q;
  assign pos_o   = pos_q;
  assign prev_o  = prev_q;
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk #(
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned LIST_BASE = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             find_i,
  input logic             add_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             found_o,
  input logic             err_o,
  input logic [OFF_W-1:0] pos_o,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic [OFF_W-3:0] mem_addr_o
);
  localparam int unsigned LAST_OK = (1 << OFF_W) - 8;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R13
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  // R13
  access_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> busy_o);
  // R1
  found_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |->
      (!err_o && pos_o >= OFF_W'(LIST_BASE) && pos_o <= OFF_W'(LAST_OK)));
  // R9
  write_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o >= (OFF_W-2)'(LIST_BASE / 4)));
  // R12
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(find_i || add_i));
endmodule

bind ecap_walker ecap_walker_chk #(.OFF_W(ecap_pkg::OFF_W), .LIST_BASE(LIST_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .find_i(find_i), .add_i(add_i),
  .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .err_o(err_o),
  .pos_o(pos_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/tb_ecap_walker.sv
module tb_ecap_walker;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_STEPS  = 1024;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        find_i = 0, add_i = 0;
  logic [15:0] cap_id_i = 0;
  logic [3:0]  cap_ver_i = 0;
  logic [11:0] offset_i = 0;
  logic [12:0] size_i = 0;
  logic        busy_o, done_o, found_o, err_o, mem_re_o, mem_we_o;
  logic [11:0] pos_o, prev_o;
  logic [9:0]  mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  logic [31:0] mem [1024];
  logic [31:0] snap [1024];
  int tests = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecap_walker #(.LIST_BASE(256), .MAX_STEPS(MAX_STEPS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .find_i(find_i), .add_i(add_i),
    .cap_id_i(cap_id_i), .cap_ver_i(cap_ver_i), .offset_i(offset_i), .size_i(size_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .err_o(err_o),
    .pos_o(pos_o), .prev_o(prev_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk) begin
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference walk over the bench memory
  task automatic ref_walk(input int key, output int f, output int p, output int pv,
                          output int e, output int n);
    int cur = 256, prv = 0;
    f = 0; p = 0; pv = 0; e = 0; n = 0;
    forever begin
      int w, nx;
      w = mem[cur/4]; n++;
      nx = (w >> 20) & 12'hfff;
      if (cur == 256 && w == 0) return;
      if (key != 0 && (w & 16'hffff) == key) begin f = 1; p = cur; pv = prv; return; end
      if (nx == 0) begin pv = cur; return; end
      if (nx < 256 || nx > 4088 || n == MAX_STEPS) begin e = 1; return; end
      prv = cur; cur = nx;
    end
  endtask

  // issue a command and wait for done; per-cycle: busy must hold until done
  task automatic run(input bit f, input bit a, input int id, input int ver, input int off,
                     input int sz, input bit poke, input string req, input int lat,
                     input int ef, input int ep, input int epv, input int ee);
    int c = 1;
    @(negedge clk);
    find_i = f; add_i = a; cap_id_i = 16'(id); cap_ver_i = 4'(ver);
    offset_i = 12'(off); size_i = 13'(sz);
    @(negedge clk);
    find_i = 0; add_i = 0;
    if (poke) begin
      find_i = 1; add_i = 1; cap_id_i = 16'h0003; offset_i = 12'h300; size_i = 13'd16;
    end
    while (!done_o && c < 5000) begin
      if (!busy_o) begin
        chk(0, {req, " busy during walk"}, busy_o, 1);
        break;
      end
      @(negedge clk); c++;
      find_i = 0; add_i = 0;
    end
    chk(c == lat, {req, " latency"}, c, lat);
    chk(found_o == ef[0], {req, " found"}, found_o, ef);
    chk(err_o == ee[0], {req, " err"}, err_o, ee);
    chk(pos_o == 12'(ep), {req, " pos"}, pos_o, ep);
    chk(prev_o == 12'(epv), {req, " prev"}, prev_o, epv);
    @(negedge clk);
    chk(!done_o, "R11 done pulse width", done_o, 0);
  endtask

  task automatic find_ref(input int key, input string req);
    int f, p, pv, e, n;
    ref_walk(key, f, p, pv, e, n);
    run(1, 0, key, 0, 0, 0, 0, req, 2*n+1, f, p, pv, e);
  endtask

  task automatic take_snap();
    for (int i = 0; i < 1024; i++) snap[i] = mem[i];
  endtask

  task automatic same_snap(input string req);
    int diff = 0;
    for (int i = 0; i < 1024; i++) if (snap[i] != mem[i]) diff++;
    chk(diff == 0, req, diff, 0);
  endtask

  task automatic add_tail(input int id, input int ver, input int off, input string req);
    int f, p, pv, e, n, old;
    ref_walk(0, f, p, pv, e, n);
    old = mem[pv/4];
    run(0, 1, id, ver, off, 32, 0, req, 2*n+3, 0, off, pv, 0);
    chk(mem[pv/4] == {12'(off), old[19:0]}, {req, " tail patch"}, mem[pv/4], {12'(off), old[19:0]});
    chk(mem[off/4] == {12'h0, 4'(ver), 16'(id)}, {req, " new header"}, mem[off/4],
        {12'h0, 4'(ver), 16'(id)});
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // reset state
    chk(!busy_o && !done_o && !found_o && !err_o, "R11 reset flags", {busy_o, done_o, found_o, err_o}, 0);
    chk(pos_o == 0 && prev_o == 0, "R11 reset results", {pos_o, prev_o}, 0);
    chk(!mem_re_o && !mem_we_o, "R13 reset strobes", {mem_re_o, mem_we_o}, 0);
    rst_ni = 1'b1;

    // R2 empty chain
    run(1, 0, 3, 0, 0, 0, 0, "R2 empty lookup", 3, 0, 0, 0, 0);
    // R10 append elsewhere on empty chain
    take_snap();
    run(0, 1, 5, 1, 320, 32, 0, "R10 append on empty", 3, 0, 0, 0, 1);
    same_snap("R10 no write on empty");

    // R7 append at head of empty chain
    run(0, 1, 3, 1, 256, 64, 0, "R7 head append", 4, 0, 256, 0, 0);
    chk(mem[64] == 32'h0001_0003, "R7 head word", mem[64], 32'h0001_0003);
    // R8 tail appends
    add_tail(16'h000E, 2, 320, "R8 append 320");
    add_tail(16'h0010, 3, 512, "R8 append 512");

    // R1 lookups
    find_ref(16'h0003, "R1 first entry");
    find_ref(16'h000E, "R1 middle entry");
    find_ref(16'h0010, "R1 last entry");
    run(1, 0, 16'h000E, 0, 0, 0, 0, "R1 middle fixed", 5, 1, 320, 256, 0);
    // R3 absent id
    run(1, 0, 16'h0055, 0, 0, 0, 0, "R3 absent", 7, 0, 0, 512, 0);
    // R4 id 0 with a stored zero id
    mem[80] = mem[80] & 32'hFFF0_0000;
    run(1, 0, 0, 0, 0, 0, 0, "R4 zero id", 7, 0, 0, 512, 0);
    mem[80] = mem[80] | 32'h0002_000E;

    // R12 busy pokes and simultaneous commands
    take_snap();
    run(1, 0, 16'h0010, 0, 0, 0, 1, "R12 poke while busy", 7, 1, 512, 320, 0);
    same_snap("R12 no write from poke");
    run(1, 1, 16'h000E, 0, 512, 32, 0, "R12 find priority", 5, 1, 320, 256, 0);
    same_snap("R12 no write from dropped append");

    // R7 head append on non-empty chain keeps next
    run(0, 1, 7, 2, 256, 64, 0, "R7 head rewrite", 4, 0, 256, 0, 0);
    chk(mem[64] == 32'h1402_0007, "R7 head keeps next", mem[64], 32'h1402_0007);

    // R9 rejections
    take_snap();
    run(0, 1, 9, 1, 322, 32, 0, "R9 misaligned", 1, 0, 0, 0, 1);
    run(0, 1, 9, 1, 128, 32, 0, "R9 below base", 1, 0, 0, 0, 1);
    run(0, 1, 9, 1, 768, 4, 0, "R9 small size", 1, 0, 0, 0, 1);
    run(0, 1, 9, 1, 4000, 96, 0, "R9 end at top", 1, 0, 0, 0, 1);
    same_snap("R9 no write on reject");

    // R5 range limits
    mem[128] = 32'hFF80_0010;
    mem[1022] = 32'h0000_0020;
    run(1, 0, 16'h0020, 0, 0, 0, 0, "R5 edge 4088 valid", 9, 1, 4088, 512, 0);
    mem[128] = 32'h0FC0_0010;
    run(1, 0, 16'h0020, 0, 0, 0, 0, "R5 pointer 252", 7, 0, 0, 0, 1);
    mem[128] = 32'hFFC0_0010;
    find_ref(16'h0020, "R5 pointer 4092");

    // R6 self loop
    mem[64] = 32'h1000_0007;
    run(1, 0, 16'h0099, 0, 0, 0, 0, "R6 loop bound", 2*MAX_STEPS+1, 0, 0, 0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule